// File: doc/BRIEF.md
# Enclave Entry Fault Checker

This block decides whether a request to start executing inside a protected memory region may go ahead. It sees everything the entry decision depends on at once: the address of the thread control page, that page's flags word, the current and maximum save-frame indices, whether the thread is already running, the attributes of the protected region, the processor's mode and control bits, the enabled-feature register, and the metadata record already fetched for the control page. Fetching that metadata and changing any architectural state are left to the surrounding logic.

When `checkStrobe` is high for a cycle, all thirteen entry conditions are evaluated in parallel. A fixed priority then selects the single most important failure. In the next cycle, `checkDone` pulses and carries the result: either `entryPass`, or a fault class (general protection or page fault) together with a 5-bit code that names the check which failed first. Outside that cycle all result outputs read zero.

Top module: `entry_guard`

## Requirements
- R1: A control address whose low 12 bits are not all zero yields faultClass 1 (general protection) with faultCode 1.
- R2: The page-fault checks yield faultClass 2 and are tested in this order: metadata not valid gives code 2; blocked gives code 3; owner address not equal to the control address, or page type not 8'h01 (thread control), gives code 4; pending or modified gives code 5.
- R3: Any set bit of flagsWord above bits 1:0 yields general protection code 6. Bit 0 is the debug opt-in flag and bit 1 is the notify flag.
- R4: A region that is not initialised yields general protection code 7. A processor 64-bit mode (longModeActive AND codeSegLong) that differs from regionMode64 yields general protection code 8.
- R5: osFxsrEn equal to 0 yields general protection code 9.
- R6: With osExtSaveEn at 0, regionMask must equal 3. With osExtSaveEn at 1, regionMask AND featureReg must equal regionMask. A violation yields general protection code 10.
- R7: With the debug opt-in flag at 0, a notify flag that differs from regionNotify yields general protection code 11. With opt-in at 1, the notify flag is not compared.
- R8: A frameIdx greater than or equal to frameCount (unsigned) yields general protection code 12.
- R9: threadActive at 1 yields general protection code 13.
- R10: When several checks fail, only the one with the lowest code is reported.
- R11: When no check fails, entryPass is 1, faultClass is 0 and faultCode is 0.
- R12: The results appear in the cycle after checkStrobe, with checkDone high for exactly that cycle. In every other cycle, and during reset, checkDone, entryPass, faultClass and faultCode are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| checkStrobe | input | 1 | One-cycle request to evaluate the entry |
| ctrlAddr | input | 64 | Address of the thread control page |
| flagsWord | input | 64 | Flags word of the control page |
| frameIdx | input | 32 | Current save-frame index |
| frameCount | input | 32 | Number of save frames available |
| threadActive | input | 1 | Thread is already in the active state |
| regionInit | input | 1 | Region has been initialised |
| regionMode64 | input | 1 | Region built for 64-bit execution |
| regionMask | input | 64 | Region feature mask |
| regionNotify | input | 1 | Region notify attribute |
| longModeActive | input | 1 | Processor long mode active |
| codeSegLong | input | 1 | Code segment 64-bit bit |
| osFxsrEn | input | 1 | OS floating-point save enable |
| osExtSaveEn | input | 1 | OS extended-save enable |
| featureReg | input | 64 | Currently enabled feature register |
| metaValid | input | 1 | Control page metadata valid |
| metaBlocked | input | 1 | Control page blocked |
| metaPending | input | 1 | Control page pending |
| metaModified | input | 1 | Control page modified |
| metaType | input | 8 | Control page type |
| metaOwner | input | 64 | Address recorded in the control page metadata |
| checkDone | output | 1 | Result valid pulse |
| entryPass | output | 1 | Entry permitted |
| faultClass | output | 2 | 0 none, 1 general protection, 2 page fault |
| faultCode | output | 5 | Index of the first failing check, 0 on pass |

## Verification
The assertions assume that every input is held stable across the edge at which checkStrobe is sampled. They also assume that the metadata record already belongs to the control address presented with the strobe. The bench changes inputs only at falling edges and presents each request's complete field set together with its strobe. It begins from a fully legal request and corrupts chosen fields, either one at a time, in deliberate combinations to test priority, or at random. This keeps each stimulus inside those assumptions while still reaching every check and both modes of the feature-mask rule.

// File: rtl/entry_guard_pkg.sv
package entry_guard_pkg;

  localparam int CODE_W = 5;
  localparam int NCHK   = 13;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_GP   = 2'd1,
    FC_PF   = 2'd2
  } faultClass_e;

  // check indices, in priority order (lowest wins)
  localparam logic [CODE_W-1:0] CK_ALIGN    = 5'd1;
  localparam logic [CODE_W-1:0] CK_MVALID   = 5'd2;
  localparam logic [CODE_W-1:0] CK_MBLOCK   = 5'd3;
  localparam logic [CODE_W-1:0] CK_MIDENT   = 5'd4;
  localparam logic [CODE_W-1:0] CK_MDIRTY   = 5'd5;
  localparam logic [CODE_W-1:0] CK_FLAGRSV  = 5'd6;
  localparam logic [CODE_W-1:0] CK_INIT     = 5'd7;
  localparam logic [CODE_W-1:0] CK_MODE     = 5'd8;
  localparam logic [CODE_W-1:0] CK_FXSR     = 5'd9;
  localparam logic [CODE_W-1:0] CK_MASK     = 5'd10;
  localparam logic [CODE_W-1:0] CK_NOTIFY   = 5'd11;
  localparam logic [CODE_W-1:0] CK_FRAME    = 5'd12;
  localparam logic [CODE_W-1:0] CK_ACTIVE   = 5'd13;

  typedef struct packed {
    logic capture;
    logic clear;
  } guardCtl_t;

  function automatic faultClass_e classOf(input logic [CODE_W-1:0] code);
    if (code == '0)
      return FC_NONE;
    else if (code >= CK_MVALID && code <= CK_MDIRTY)
      return FC_PF;
    else
      return FC_GP;
  endfunction

endpackage

// File: rtl/entry_guard_ctl.sv
module entry_guard_ctl
  import entry_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      checkStrobe,
  output guardCtl_t ctl,
  output logic      checkDone
);

  always_comb begin
    ctl.capture = checkStrobe;
    ctl.clear   = ~checkStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) checkDone <= 1'b0;
    else        checkDone <= checkStrobe;
  end

endmodule

// File: rtl/entry_guard_dp.sv
module entry_guard_dp
  import entry_guard_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int FLAG_W    = 64,
  parameter int IDX_W     = 32,
  parameter int MASK_W    = 64,
  parameter int TYPE_W    = 8,
  parameter int PAGE_BITS = 12,
  parameter logic [TYPE_W-1:0] CTRL_PAGE_TYPE = 8'h01
)(
  input  logic              clk,
  input  logic              rst_n,
  input  guardCtl_t         ctl,
  input  logic [ADDR_W-1:0] ctrlAddr,
  input  logic [FLAG_W-1:0] flagsWord,
  input  logic [IDX_W-1:0]  frameIdx,
  input  logic [IDX_W-1:0]  frameCount,
  input  logic              threadActive,
  input  logic              regionInit,
  input  logic              regionMode64,
  input  logic [MASK_W-1:0] regionMask,
  input  logic              regionNotify,
  input  logic              longModeActive,
  input  logic              codeSegLong,
  input  logic              osFxsrEn,
  input  logic              osExtSaveEn,
  input  logic [MASK_W-1:0] featureReg,
  input  logic              metaValid,
  input  logic              metaBlocked,
  input  logic              metaPending,
  input  logic              metaModified,
  input  logic [TYPE_W-1:0] metaType,
  input  logic [ADDR_W-1:0] metaOwner,
  output logic              entryPass,
  output logic [1:0]        faultClass,
  output logic [CODE_W-1:0] faultCode
);

  localparam int OPTIN_BIT  = 0;
  localparam int NOTIFY_BIT = 1;
  localparam logic [FLAG_W-1:0] FLAG_KEEP   = FLAG_W'(2'b11);
  localparam logic [MASK_W-1:0] LEGACY_MASK = MASK_W'(2'b11);

  logic [NCHK:1]      failVec;
  logic [CODE_W-1:0]  firstCode;
  logic               cpuMode64;
  logic               maskOk;

  assign cpuMode64 = longModeActive & codeSegLong;
  assign maskOk    = osExtSaveEn ? ((regionMask & featureReg) == regionMask)
                                 : (regionMask == LEGACY_MASK);

  always_comb begin
    failVec             = '0;
    failVec[CK_ALIGN]   = |ctrlAddr[PAGE_BITS-1:0];
    failVec[CK_MVALID]  = ~metaValid;
    failVec[CK_MBLOCK]  = metaBlocked;
    failVec[CK_MIDENT]  = (metaOwner != ctrlAddr) || (metaType != CTRL_PAGE_TYPE);
    failVec[CK_MDIRTY]  = metaPending | metaModified;
    failVec[CK_FLAGRSV] = |(flagsWord & ~FLAG_KEEP);
    failVec[CK_INIT]    = ~regionInit;
    failVec[CK_MODE]    = cpuMode64 ^ regionMode64;
    failVec[CK_FXSR]    = ~osFxsrEn;
    failVec[CK_MASK]    = ~maskOk;
    failVec[CK_NOTIFY]  = ~flagsWord[OPTIN_BIT] & (flagsWord[NOTIFY_BIT] ^ regionNotify);
    failVec[CK_FRAME]   = (frameIdx >= frameCount);
    failVec[CK_ACTIVE]  = threadActive;
  end

  // lowest-numbered failing check wins
  always_comb begin
    firstCode = '0;
    for (int k = NCHK; k >= 1; k--) begin
      if (failVec[k]) firstCode = CODE_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.clear) begin
      entryPass  <= 1'b0;
      faultClass <= FC_NONE;
      faultCode  <= '0;
    end else if (ctl.capture) begin
      entryPass  <= (firstCode == '0);
      faultClass <= classOf(firstCode);
      faultCode  <= firstCode;
    end
  end

endmodule

// File: rtl/entry_guard.sv
module entry_guard
  import entry_guard_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int FLAG_W    = 64,
  parameter int IDX_W     = 32,
  parameter int MASK_W    = 64,
  parameter int TYPE_W    = 8,
  parameter int PAGE_BITS = 12
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              checkStrobe,
  input  logic [ADDR_W-1:0] ctrlAddr,
  input  logic [FLAG_W-1:0] flagsWord,
  input  logic [IDX_W-1:0]  frameIdx,
  input  logic [IDX_W-1:0]  frameCount,
  input  logic              threadActive,
  input  logic              regionInit,
  input  logic              regionMode64,
  input  logic [MASK_W-1:0] regionMask,
  input  logic              regionNotify,
  input  logic              longModeActive,
  input  logic              codeSegLong,
  input  logic              osFxsrEn,
  input  logic              osExtSaveEn,
  input  logic [MASK_W-1:0] featureReg,
  input  logic              metaValid,
  input  logic              metaBlocked,
  input  logic              metaPending,
  input  logic              metaModified,
  input  logic [TYPE_W-1:0] metaType,
  input  logic [ADDR_W-1:0] metaOwner,
  output logic              checkDone,
  output logic              entryPass,
  output logic [1:0]        faultClass,
  output logic [4:0]        faultCode
);

  guardCtl_t ctl;

  entry_guard_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .checkStrobe (checkStrobe),
    .ctl         (ctl),
    .checkDone   (checkDone)
  );

  entry_guard_dp #(
    .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W),
    .MASK_W(MASK_W), .TYPE_W(TYPE_W), .PAGE_BITS(PAGE_BITS)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl            (ctl),
    .ctrlAddr       (ctrlAddr),
    .flagsWord      (flagsWord),
    .frameIdx       (frameIdx),
    .frameCount     (frameCount),
    .threadActive   (threadActive),
    .regionInit     (regionInit),
    .regionMode64   (regionMode64),
    .regionMask     (regionMask),
    .regionNotify   (regionNotify),
    .longModeActive (longModeActive),
    .codeSegLong    (codeSegLong),
    .osFxsrEn       (osFxsrEn),
    .osExtSaveEn    (osExtSaveEn),
    .featureReg     (featureReg),
    .metaValid      (metaValid),
    .metaBlocked    (metaBlocked),
    .metaPending    (metaPending),
    .metaModified   (metaModified),
    .metaType       (metaType),
    .metaOwner      (metaOwner),
    .entryPass      (entryPass),
    .faultClass     (faultClass),
    .faultCode      (faultCode)
  );

endmodule

// File: rtl/entry_guard_chk.sv
module entry_guard_chk #(
  parameter int ADDR_W    = 64,
  parameter int FLAG_W    = 64,
  parameter int IDX_W     = 32,
  parameter int MASK_W    = 64,
  parameter int TYPE_W    = 8,
  parameter int PAGE_BITS = 12
)(
  input logic              clk,
  input logic              rst_n,
  input logic              checkStrobe,
  input logic [ADDR_W-1:0] ctrlAddr,
  input logic [FLAG_W-1:0] flagsWord,
  input logic [IDX_W-1:0]  frameIdx,
  input logic [IDX_W-1:0]  frameCount,
  input logic              threadActive,
  input logic              osFxsrEn,
  input logic              metaValid,
  input logic              checkDone,
  input logic              entryPass,
  input logic [1:0]        faultClass,
  input logic [4:0]        faultCode
);

  p_align_gp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (checkStrobe && ctrlAddr[PAGE_BITS-1:0] != '0) |=> (faultClass == 2'd1 && faultCode == 5'd1));

  p_meta_invalid_pf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (checkStrobe && ctrlAddr[PAGE_BITS-1:0] == '0 && !metaValid) |=> (faultClass == 2'd2 && faultCode == 5'd2));

  p_page_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (faultClass == 2'd2) |-> (faultCode >= 5'd2 && faultCode <= 5'd5));

  p_flags_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (checkStrobe && flagsWord[FLAG_W-1:2] != '0) |=> (!entryPass && faultCode != 5'd0 && faultCode <= 5'd6));

  p_fxsr_no_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (checkStrobe && !osFxsrEn) |=> (!entryPass && faultCode <= 5'd9));

  p_frame_no_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (checkStrobe && frameIdx >= frameCount) |=> !entryPass);

  p_active_no_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (checkStrobe && threadActive) |=> !entryPass);

  p_pass_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    entryPass |-> (checkDone && faultClass == 2'd0 && faultCode == 5'd0));

  p_fault_has_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (checkDone && !entryPass) |-> (faultClass != 2'd0 && faultCode != 5'd0));

  p_done_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    checkStrobe |=> checkDone);

  p_done_drops_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !checkStrobe |=> !checkDone);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !checkDone |-> (!entryPass && faultClass == 2'd0 && faultCode == 5'd0));

endmodule

bind entry_guard entry_guard_chk #(
  .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .IDX_W(IDX_W),
  .MASK_W(MASK_W), .TYPE_W(TYPE_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .checkStrobe  (checkStrobe),
  .ctrlAddr     (ctrlAddr),
  .flagsWord    (flagsWord),
  .frameIdx     (frameIdx),
  .frameCount   (frameCount),
  .threadActive (threadActive),
  .osFxsrEn     (osFxsrEn),
  .metaValid    (metaValid),
  .checkDone    (checkDone),
  .entryPass    (entryPass),
  .faultClass   (faultClass),
  .faultCode    (faultCode)
);

// File: tb/entry_guard_test.sv
`timescale 1ns/1ps
module entry_guard_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        checkStrobe = 1'b0;
  logic [63:0] ctrlAddr, flagsWord, regionMask, featureReg, metaOwner;
  logic [31:0] frameIdx, frameCount;
  logic        threadActive, regionInit, regionMode64, regionNotify;
  logic        longModeActive, codeSegLong, osFxsrEn, osExtSaveEn;
  logic        metaValid, metaBlocked, metaPending, metaModified;
  logic [7:0]  metaType;
  logic        checkDone, entryPass;
  logic [1:0]  faultClass;
  logic [4:0]  faultCode;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  entry_guard uut (.*);

  // reference model straight from the requirements
  function automatic int refCode();
    if (ctrlAddr[11:0] != 0)                                   return 1;  // R1
    if (!metaValid)                                            return 2;  // R2
    if (metaBlocked)                                           return 3;
    if (metaOwner != ctrlAddr || metaType != 8'h01)            return 4;
    if (metaPending || metaModified)                           return 5;
    if (flagsWord[63:2] != 0)                                  return 6;  // R3
    if (!regionInit)                                           return 7;  // R4
    if ((longModeActive && codeSegLong) != regionMode64)       return 8;
    if (!osFxsrEn)                                             return 9;  // R5
    if (osExtSaveEn ? ((regionMask & featureReg) != regionMask)
                    : (regionMask != 64'd3))                   return 10; // R6
    if (!flagsWord[0] && (flagsWord[1] != regionNotify))       return 11; // R7
    if (frameIdx >= frameCount)                                return 12; // R8
    if (threadActive)                                          return 13; // R9
    return 0;                                                             // R11
  endfunction

  function automatic string tagOf(input int code);
    case (code)
      0:  return "R11";
      1:  return "R1";
      2, 3, 4, 5: return "R2";
      6:  return "R3";
      7, 8: return "R4";
      9:  return "R5";
      10: return "R6";
      11: return "R7";
      12: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic setGood();
    ctrlAddr = 64'h0000_0000_1234_5000;
    metaOwner = ctrlAddr;
    metaType = 8'h01;
    metaValid = 1'b1; metaBlocked = 1'b0; metaPending = 1'b0; metaModified = 1'b0;
    flagsWord = 64'd0;
    frameIdx = 32'd0; frameCount = 32'd2;
    threadActive = 1'b0; regionInit = 1'b1; regionMode64 = 1'b1;
    longModeActive = 1'b1; codeSegLong = 1'b1;
    osFxsrEn = 1'b1; osExtSaveEn = 1'b1;
    featureReg = 64'h7; regionMask = 64'h3; regionNotify = 1'b0;
  endtask

  // one cycle: strobe set at a falling edge, result compared at the next one
  task automatic step(input logic strb, input string tag);
    logic       eDone, ePass;
    logic [1:0] eClass;
    logic [4:0] eCode;
    int c;
    string t;
    c = refCode();
    checkStrobe = strb;
    eDone  = strb;
    ePass  = strb && (c == 0);
    eCode  = strb ? 5'(c) : 5'd0;
    eClass = !strb || c == 0 ? 2'd0 : ((c >= 2 && c <= 5) ? 2'd2 : 2'd1);
    t = (tag != "") ? tag : (strb ? tagOf(c) : "R12");
    @(negedge clk);
    nChecks++;
    if ({checkDone, entryPass, faultClass, faultCode} != {eDone, ePass, eClass, eCode}) begin
      nFails++;
      $display("FAIL %s done/pass/class/code actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
               t, checkDone, entryPass, faultClass, faultCode, eDone, ePass, eClass, eCode);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    setGood();
    repeat (3) @(negedge clk);
    nChecks++;   // R12 reset state
    if ({checkDone, entryPass, faultClass, faultCode} != 9'd0) begin
      nFails++;
      $display("FAIL R12 reset outputs actual=%0d/%0d/%0d/%0d expected=0/0/0/0",
               checkDone, entryPass, faultClass, faultCode);
    end
    rst_n = 1'b1;
    step(1'b0, "R12");
    step(1'b1, "R11");
    step(1'b0, "R12");           // result held for one cycle only
    // single faults
    setGood(); ctrlAddr[3] = 1'b1; metaOwner = ctrlAddr; step(1'b1, "R1");
    setGood(); metaValid = 1'b0;   step(1'b1, "R2");
    setGood(); metaBlocked = 1'b1; step(1'b1, "R2");
    setGood(); metaOwner[20] = 1'b1; step(1'b1, "R2");
    setGood(); metaType = 8'h02;   step(1'b1, "R2");
    setGood(); metaPending = 1'b1; step(1'b1, "R2");
    setGood(); metaModified = 1'b1; step(1'b1, "R2");
    setGood(); flagsWord[63] = 1'b1; step(1'b1, "R3");
    setGood(); flagsWord[2] = 1'b1;  step(1'b1, "R3");
    setGood(); flagsWord = 64'h3; regionNotify = 1'b0; step(1'b1, "R7"); // opt-in skips notify
    setGood(); regionInit = 1'b0;  step(1'b1, "R4");
    setGood(); codeSegLong = 1'b0; step(1'b1, "R4");
    setGood(); longModeActive = 1'b0; codeSegLong = 1'b0; regionMode64 = 1'b0; step(1'b1, "R4");
    setGood(); osFxsrEn = 1'b0;    step(1'b1, "R5");
    setGood(); regionMask = 64'hF; step(1'b1, "R6");
    setGood(); osExtSaveEn = 1'b0; step(1'b1, "R6");
    setGood(); osExtSaveEn = 1'b0; regionMask = 64'h1; featureReg = 64'hFF; step(1'b1, "R6");
    setGood(); regionMask = 64'h7; step(1'b1, "R6");
    setGood(); flagsWord = 64'h2;  step(1'b1, "R7");
    setGood(); flagsWord = 64'h2; regionNotify = 1'b1; step(1'b1, "R7");
    setGood(); frameIdx = 32'd2;   step(1'b1, "R8");
    setGood(); frameIdx = 32'd1;   step(1'b1, "R8");
    setGood(); frameCount = 32'd0; step(1'b1, "R8");
    setGood(); threadActive = 1'b1; step(1'b1, "R9");
    // priority among several failures
    setGood(); threadActive = 1'b1; frameIdx = 32'd9; osFxsrEn = 1'b0; step(1'b1, "R10");
    setGood(); metaPending = 1'b1; metaBlocked = 1'b1; flagsWord[40] = 1'b1; step(1'b1, "R10");
    setGood(); ctrlAddr[0] = 1'b1; metaValid = 1'b0; threadActive = 1'b1; step(1'b1, "R10");
    setGood(); regionInit = 1'b0; codeSegLong = 1'b0; regionMask = 64'hF0; step(1'b1, "R10");
    // back-to-back strobes, then idle with a faulty setup
    setGood(); step(1'b1, "R12");
    threadActive = 1'b1; step(1'b1, "R12");
    step(1'b0, "R12");
    // random mixes
    for (int i = 0; i < 400; i++) begin
      setGood();
      if ($urandom_range(0, 15) == 0) ctrlAddr[$urandom_range(0, 11)] = 1'b1;
      if ($urandom_range(0, 15) == 0) metaValid = 1'b0;
      if ($urandom_range(0, 15) == 0) metaBlocked = 1'b1;
      if ($urandom_range(0, 15) == 0) metaOwner[$urandom_range(12, 63)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) metaType = 8'($urandom);
      if ($urandom_range(0, 15) == 0) metaPending = 1'b1;
      if ($urandom_range(0, 15) == 0) metaModified = 1'b1;
      if ($urandom_range(0, 7) == 0)  flagsWord = {62'd0, 2'($urandom)};
      if ($urandom_range(0, 31) == 0) flagsWord[$urandom_range(2, 63)] = 1'b1;
      if ($urandom_range(0, 15) == 0) regionInit = 1'b0;
      if ($urandom_range(0, 15) == 0) codeSegLong = 1'($urandom);
      if ($urandom_range(0, 15) == 0) regionMode64 = 1'($urandom);
      if ($urandom_range(0, 15) == 0) osFxsrEn = 1'b0;
      if ($urandom_range(0, 7) == 0)  osExtSaveEn = 1'($urandom);
      if ($urandom_range(0, 7) == 0)  regionMask = 64'($urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0)  featureReg = 64'($urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0)  regionNotify = 1'($urandom);
      if ($urandom_range(0, 7) == 0)  frameIdx = 32'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0)  frameCount = 32'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) threadActive = 1'b1;
      step(1'($urandom_range(0, 3) != 0), "");
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule